// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial front end of a small byte-addressed non-volatile store. During a write command it collects data bytes into a 16-byte page buffer. The start address picks the page and the first slot. Each later byte goes to the next slot, and the slot index wraps inside the page. Nothing reaches the array while the command is still open.

The command ends when chip select rises. The buffered bytes are committed only if that rise lands exactly on a byte boundary, the write-enable latch was set when the command began, and at least one data byte arrived. In every other case the buffer is dropped. A committed write first copies the buffered slots into the array, one per clock, skipping any address that the two block-protect bits cover. It then runs a self-timed wait. Write-in-progress stays high through both phases. When the wait ends, the write-enable latch is cleared.

Top module: `page_write_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wip`, `wel` and `arr_we` are 0.
- R2: A `wel_set` pulse while `wip` is 0 and no command is open sets `wel` from the next cycle. A `wel_set` pulse while `wip` is 1 is ignored.
- R3: A `wr_start` while `wel` is 0 is rejected. No array byte changes and `wip` stays 0.
- R4: Data byte k of an accepted command (k = 0, 1, ...) goes to address {start_addr[7:4], (start_addr[3:0] + k) mod 16}. The upper four address bits never change, so the write wraps inside its page.
- R5: When more than 16 data bytes arrive, a later byte replaces the earlier byte held for the same address. Only the last value per address is written.
- R6: A command is committed only when `cs_rise` comes with `on_boundary` = 1 and at least one data byte was received. Any other end discards all bytes. In that case `wip` stays 0 and `wel` keeps its value.
- R7: `wip` rises in the cycle after the committing `cs_rise`. It stays high for exactly 16 + WRITE_CYCLES cycles.
- R8: `wel` falls to 0 in the same cycle that `wip` falls at the end of a committed write.
- R9: Block protect `bp` = 00 protects nothing, 01 protects C0h–FFh, 10 protects 80h–FFh and 11 protects the whole array. A protected address is never written; an unprotected one in the same write is.
- R10: A `byte_valid` strobe in the same cycle as the committing `cs_rise` is part of the command. That byte is written.
- R11: While `wip` is 1, `wr_start`, `byte_valid` and `cs_rise` have no effect on the array or on `wel`.
- R12: The array port writes one byte per cycle, and only while `wip` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_set | input | 1 | Pulse: a completed write-enable command |
| bp | input | 2 | Block-protect level |
| wr_start | input | 1 | Pulse: write opcode and address received |
| start_addr | input | 8 | Start address of the write |
| byte_valid | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Data byte qualified by byte_valid |
| cs_rise | input | 1 | Pulse: chip select went inactive |
| on_boundary | input | 1 | With cs_rise: bit count was a multiple of 8 |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 8 | Array byte address |
| arr_wdata | output | 8 | Array byte write data |

## Verification
Two events can fall in the same cycle: the last data strobe and the chip-select rise that closes the command. The bench drives both on one clock edge for the final byte and then checks the array copy. That byte must be present at its wrapped address, and `wip` must still rise one cycle later. A second overlap comes from new commands, data strobes and `wel_set` pulses arriving while the timed cycle runs. These are judged by checking that the array image and `wel` are unchanged once `wip` falls.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 8;
    parameter int OFF_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_TIMED
    } pwe_state_e;

    // Protect levels: none, top quarter, top half, everything.
    function automatic logic pwe_blocked(input logic [1:0] lvl,
                                         input logic [ADDR_W-1:0] a);
        logic res;
        unique case (lvl)
            2'b00:   res = 1'b0;
            2'b01:   res = &a[ADDR_W-1 -: 2];
            2'b10:   res = a[ADDR_W-1];
            default: res = 1'b1;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/pwe_page_buffer.sv
module pwe_page_buffer #(
    parameter int SLOT_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_slot,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int SLOTS = 1 << SLOT_W;

    logic [BYTE_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  vld_q;
    logic [SLOT_W-1:0] ptr_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && ptr_q == SLOT_W'(s)) begin
                slot_q[s] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (load) begin
            vld_q <= '0;
            ptr_q <= load_slot;
        end else if (push) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q        <= ptr_q + 1'b1;
        end
    end

    assign rd_data   = slot_q[rd_slot];
    assign rd_valid  = vld_q[rd_slot];
    assign any_valid = |vld_q;

    // R4
    push_store_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !load) |=> (vld_q[$past(ptr_q)] && ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/pwe_cycle_timer.sv
module pwe_cycle_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == CNT_W'(CYCLES - 1)) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = busy && (cnt_q == CNT_W'(CYCLES - 1));

    // R7
    timer_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy);
    // R7
    timer_go_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pwe_pkg::*;
#(
    parameter int WRITE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wel_set,
    input  logic [1:0]        bp,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              on_boundary,
    output logic              wel,
    output logic              wip,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;

    pwe_state_e        state_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  idx_q;
    logic              wel_q;

    logic              buf_load, buf_push, buf_any, slot_valid;
    logic [DATA_W-1:0] slot_data;
    logic              tmr_start, tmr_busy, tmr_done;
    logic              commit_ok;

    assign buf_load  = (state_q == ST_IDLE) && wr_start && wel_q;
    assign buf_push  = (state_q == ST_COLLECT) && byte_valid;
    assign commit_ok = cs_rise && on_boundary && (buf_any || byte_valid);
    assign tmr_start = (state_q == ST_COMMIT) && (idx_q == OFF_W'(PAGE_BYTES - 1));

    pwe_page_buffer #(.SLOT_W(OFF_W), .BYTE_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (buf_load),
        .load_slot (start_addr[OFF_W-1:0]),
        .push      (buf_push),
        .push_data (byte_data),
        .rd_slot   (idx_q),
        .rd_data   (slot_data),
        .rd_valid  (slot_valid),
        .any_valid (buf_any)
    );

    pwe_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (buf_load) begin
                        state_q <= ST_COLLECT;
                        page_q  <= start_addr[ADDR_W-1:OFF_W];
                    end
                end
                ST_COLLECT: begin
                    if (cs_rise) begin
                        idx_q   <= '0;
                        state_q <= commit_ok ? ST_COMMIT : ST_IDLE;
                    end
                end
                ST_COMMIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (tmr_start) begin
                        state_q <= ST_TIMED;
                    end
                end
                default: begin
                    if (tmr_done) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
        end else if (state_q == ST_TIMED && tmr_done) begin
            wel_q <= 1'b0;
        end else if (state_q == ST_IDLE && wel_set) begin
            wel_q <= 1'b1;
        end
    end

    assign wel       = wel_q;
    assign wip       = (state_q == ST_COMMIT) || (state_q == ST_TIMED);
    assign arr_addr  = {page_q, idx_q};
    assign arr_wdata = slot_data;
    assign arr_we    = (state_q == ST_COMMIT) && slot_valid && !pwe_blocked(bp, arr_addr);

    // R7
    wip_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(cs_rise && on_boundary));
    // R3
    wip_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> wel);
    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wel) |-> $fell(wip));
    // R12
    we_in_wip_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (wip && tmr_busy == 1'b0));
    // R11
    wip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wip && !tmr_done) |=> wip);
endmodule

// File: tb/test_page_write_engine.sv
module test_page_write_engine;
    localparam int WC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wel_set = 1'b0;
    logic [1:0] bp = 2'b00;
    logic       wr_start = 1'b0;
    logic [7:0] start_addr = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cs_rise = 1'b0;
    logic       on_boundary = 1'b0;
    logic       wel, wip, arr_we;
    logic [7:0] arr_addr, arr_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    bit exp_wel = 0;

    always #5 clk = ~clk;

    page_write_engine #(.WRITE_CYCLES(WC)) i_page_write_engine (
        .clk(clk), .rst(rst), .wel_set(wel_set), .bp(bp),
        .wr_start(wr_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .on_boundary(on_boundary),
        .wel(wel), .wip(wip), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 256; a++) mem[a] <= 8'h00;
        end else if (arr_we) begin
            mem[arr_addr] <= arr_wdata;
        end
    end

    function automatic bit prot(input logic [1:0] lvl, input logic [7:0] a);
        case (lvl)
            2'b00:   return 0;
            2'b01:   return a >= 8'hC0;
            2'b10:   return a >= 8'h80;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int fa = 0;
        for (int a = 0; a < 256; a++) begin
            if (mem[a] !== exp_mem[a]) begin
                if (bad == 0) fa = a;
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("array byte %0h", fa), int'(mem[fa]), int'(exp_mem[fa]));
    endtask

    task automatic set_wel(input string req);
        @(negedge clk);
        wel_set = 1'b1;
        @(negedge clk);
        wel_set = 1'b0;
        if (!wip) exp_wel = 1;
        check(wel == exp_wel, req, "wel after set", int'(wel), int'(exp_wel));
    endtask

    // Full write command; merge puts the final strobe on the cs_rise cycle.
    task automatic do_write(input logic [7:0] addr, input int n, input logic [7:0] seed,
                            input bit bnd, input bit merge, input string req);
        bit commit;
        int cnt;
        commit = exp_wel && bnd && (n > 0);
        @(negedge clk);
        wr_start = 1'b1;
        start_addr = addr;
        @(negedge clk);
        wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data = seed + 8'(i);
            if (merge && i == n - 1) begin
                cs_rise = 1'b1;
                on_boundary = bnd;
            end
            @(negedge clk);
        end
        byte_valid = 1'b0;
        if (!(merge && n > 0)) begin
            cs_rise = 1'b1;
            on_boundary = bnd;
            @(negedge clk);
        end
        cs_rise = 1'b0;
        on_boundary = 1'b0;
        check(wip == commit, req, "wip after cs rise", int'(wip), int'(commit));
        if (commit) begin
            for (int i = 0; i < n; i++) begin
                logic [7:0] a;
                a = {addr[7:4], addr[3:0] + 4'(i)};
                if (!prot(bp, a)) exp_mem[a] = seed + 8'(i);
            end
            cnt = 0;
            while (wip) begin
                cnt++;
                @(negedge clk);
            end
            exp_wel = 0;
            check(cnt == 16 + WC, "R7", "wip length", cnt, 16 + WC);
            check(wel == 0, "R8", "wel after cycle", int'(wel), 0);
        end else begin
            @(negedge clk);
            check(wip == 0 && wel == exp_wel, req, "wel kept, no cycle",
                  int'({wip, wel}), int'({1'b0, exp_wel}));
        end
        cmp_mem(req);
    endtask

    task automatic t_reset;
        check(wip == 0 && wel == 0 && arr_we == 0, "R1", "outputs in reset",
              int'({wip, wel, arr_we}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wip == 0 && wel == 0 && arr_we == 0, "R1", "outputs after reset",
              int'({wip, wel, arr_we}), 0);
    endtask

    task automatic t_busy_ignore;
        int cnt;
        set_wel("R2");
        @(negedge clk);
        wr_start = 1'b1; start_addr = 8'h60;
        @(negedge clk);
        wr_start = 1'b0; byte_valid = 1'b1; byte_data = 8'hA5;
        @(negedge clk);
        byte_valid = 1'b0; cs_rise = 1'b1; on_boundary = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0; on_boundary = 1'b0;
        exp_mem[8'h60] = 8'hA5;
        cnt = 0;
        while (wip) begin
            cnt++;
            wr_start = (cnt % 7 == 1); start_addr = 8'h60;
            byte_valid = (cnt % 3 == 0); byte_data = 8'h5A;
            cs_rise = (cnt % 11 == 5); on_boundary = 1'b1;
            wel_set = (cnt % 5 == 2);
            @(negedge clk);
        end
        {wr_start, byte_valid, cs_rise, on_boundary, wel_set} = '0;
        exp_wel = 0;
        @(negedge clk);
        check(wel == 0, "R2", "wel_set during wip ignored", int'(wel), 0);
        check(wip == 0, "R11", "no extra cycle", int'(wip), 0);
        cmp_mem("R11");
    endtask

    initial begin
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        do_write(8'h20, 3, 8'h10, 1, 0, "R3");
        set_wel("R2");
        do_write(8'h12, 4, 8'h40, 1, 0, "R4");
        set_wel("R2");
        do_write(8'h3C, 6, 8'h70, 1, 0, "R4");
        set_wel("R2");
        do_write(8'h50, 20, 8'h90, 1, 0, "R5");
        set_wel("R2");
        do_write(8'h44, 3, 8'h22, 0, 0, "R6");
        do_write(8'h44, 0, 8'h22, 1, 0, "R6");
        do_write(8'h44, 2, 8'h33, 1, 1, "R10");
        bp = 2'b01;
        set_wel("R2"); do_write(8'hC4, 4, 8'hE0, 1, 0, "R9");
        set_wel("R2"); do_write(8'hB8, 4, 8'hE8, 1, 0, "R9");
        bp = 2'b10;
        set_wel("R2"); do_write(8'h80, 16, 8'h01, 1, 0, "R9");
        set_wel("R2"); do_write(8'h70, 16, 8'h81, 1, 0, "R9");
        bp = 2'b11;
        set_wel("R2"); do_write(8'h00, 8, 8'hC1, 1, 0, "R9");
        bp = 2'b00;
        set_wel("R2"); do_write(8'h9F, 3, 8'hD0, 1, 1, "R10");
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule